// File: doc/BRIEF.md
# External Interrupt Controller

This block gathers 64 external interrupt lines and turns them into a single request toward a processor. Software configures each line through a register window on a simple 32-bit write/read port. Each line has an enable pair, a sense mode, a priority and two stored fields that the block itself does not use. Every cycle the block selects the enabled, pending line with the highest priority and presents its number in a status register. A code of 63 in that register means that no line is pending.

Four lines, 47 to 50, can latch an edge instead of following a level. A latched edge stays pending until software names the line in a write to a shared clear register. Two global gates control the request. A detection gate stops all pending state. An output gate holds back the request line.

The request output comes from a two-state machine. `IRQ_IDLE` moves to `IRQ_ACTIVE` on the transition *fire*, when the selected code is valid and both gates are set. `IRQ_ACTIVE` returns to `IRQ_IDLE` on the transition *quiet*, when any of those conditions is lost. Otherwise each state holds.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the status code (0x144, bits 31:24) reads 63, `irq_req` is low, and the level mask (0x084), detection enable (0x004) and output enable (0x444) all read 0.
- R2: Per-source word 0 at 0x200+8*s reads back only the enable pair [29:28], sense [25:24], a 3-bit field [18:16] and a node field [7:4]. Word 1 at +4 reads back only the priority in [7:0]. All other bits read 0.
- R3: A source can be selected only when both enable bits [29:28] are 1. Values 00, 01 and 10 keep it out.
- R4: For level sense, bit 24 gives polarity: 1 is active-high, 0 is active-low. The source is pending exactly while its input is at that level. Sources other than 47..50 always use level sense, whatever is in bit 25.
- R5: Sources 47..50 with sense 3 latch a rising edge and with sense 2 latch a falling edge. The latched edge stays pending after the input returns.
- R6: A write to 0x0C0 with bit 8 set clears the latched edge of the edge source whose number has the low nibble given in bits 3:0 (47=F, 48=0, 49=1, 50=2). A write with bit 8 clear changes nothing.
- R7: Among pending sources the highest priority wins and ties go to the lowest source number. The status register shows the winner in bits 31:24 with all other bits 0, and shows 63 when nothing is pending.
- R8: While bit 0 of 0x004 is 0, no source is pending, the code reads 63, `irq_req` is low, and no edge is latched.
- R9: `irq_req` is high exactly when the code is not 63 and bit 0 of both 0x004 and 0x444 is 1. Code and request follow a level change one clock later and an edge two clocks later.
- R10: Source 63 alone can never raise `irq_req`, since its number is the "nothing pending" code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte address of register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| src_in | input | 64 | Raw interrupt lines |
| irq_req | output | 1 | Interrupt request to processor |

## Verification
The properties assume that the raw lines are sampled as synchronous inputs. They also assume that the enable and priority settings change only through register writes. The stimulus drives every line and every write half a period away from the rising edge, so each change is seen at one known edge. Random phases keep the edge-capable lines in level sense, so the bench's level model stays exact. Edge behaviour is covered by directed sequences with known settle times.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam logic [11:0] A_DET_EN   = 12'h004;
    localparam logic [11:0] A_LVL_MASK = 12'h084;
    localparam logic [11:0] A_EDGE_CLR = 12'h0C0;
    localparam logic [11:0] A_STATUS   = 12'h144;
    localparam logic [11:0] A_OUT_EN   = 12'h444;
    localparam logic [2:0]  CFG_PAGE   = 3'b001;   // 0x200..0x3FF

    localparam int PRIO_W = 8;

    typedef struct packed {
        logic [1:0]        en;
        logic [1:0]        sense;
        logic [2:0]        fld;
        logic [3:0]        node;
        logic [PRIO_W-1:0] prio;
    } src_cfg_t;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_ACTIVE
    } irq_state_e;

endpackage

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
    import ext_irq_pkg::*;
#(
    parameter int NSRC  = 64,
    parameter int SRC_W = $clog2(NSRC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [11:0]           addr,
    input  logic [31:0]           wdata,
    input  logic [SRC_W-1:0]      code,
    output src_cfg_t [NSRC-1:0]   cfg,
    output logic                  det_en,
    output logic                  out_en,
    output logic                  clr_vld,
    output logic [3:0]            clr_idx,
    output logic [31:0]           rdata
);

    localparam int SIDX_LSB = 3;

    logic [31:0]      lvl_mask_q;
    logic             in_cfg;
    logic [SRC_W-1:0] sidx;

    assign in_cfg  = (addr[11:9] == CFG_PAGE) && (int'(addr[SIDX_LSB +: SRC_W]) < NSRC);
    assign sidx    = addr[SIDX_LSB +: SRC_W];
    assign clr_vld = wr_en && (addr == A_EDGE_CLR) && wdata[8];
    assign clr_idx = wdata[3:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg        <= '0;
            det_en     <= 1'b0;
            out_en     <= 1'b0;
            lvl_mask_q <= '0;
        end else if (wr_en) begin
            if (addr == A_DET_EN)   det_en     <= wdata[0];
            if (addr == A_OUT_EN)   out_en     <= wdata[0];
            if (addr == A_LVL_MASK) lvl_mask_q <= wdata;
            if (in_cfg) begin
                if (!addr[2]) begin
                    cfg[sidx].en    <= wdata[29:28];
                    cfg[sidx].sense <= wdata[25:24];
                    cfg[sidx].fld   <= wdata[18:16];
                    cfg[sidx].node  <= wdata[7:4];
                end else begin
                    cfg[sidx].prio  <= wdata[PRIO_W-1:0];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_DET_EN)        rdata = {31'b0, det_en};
        else if (addr == A_OUT_EN)   rdata = {31'b0, out_en};
        else if (addr == A_LVL_MASK) rdata = lvl_mask_q;
        else if (addr == A_STATUS)   rdata = {8'(code), 24'b0};
        else if (in_cfg) begin
            if (!addr[2])
                rdata = {2'b0, cfg[sidx].en, 2'b0, cfg[sidx].sense, 5'b0,
                         cfg[sidx].fld, 8'b0, cfg[sidx].node, 4'b0};
            else
                rdata = {{(32-PRIO_W){1'b0}}, cfg[sidx].prio};
        end
    end

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import ext_irq_pkg::*;
#(
    parameter int NSRC    = 64,
    parameter int EDGE_LO = 47,
    parameter int N_EDGE  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     src_in,
    input  src_cfg_t [NSRC-1:0] cfg,
    input  logic                det_en,
    input  logic                clr_vld,
    input  logic [3:0]          clr_idx,
    output logic [NSRC-1:0]     pend
);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic active;
        logic en_ok;
        assign active = cfg[i].sense[0] ? src_in[i] : ~src_in[i];
        assign en_ok  = (cfg[i].en == 2'b11);

        if (i >= EDGE_LO && i < EDGE_LO + N_EDGE) begin : g_edge
            logic prev_q, cap_q, hit, clr;
            assign hit = cfg[i].sense[1] && det_en &&
                         (cfg[i].sense[0] ? (src_in[i] & ~prev_q) : (~src_in[i] & prev_q));
            assign clr = clr_vld && (clr_idx == 4'(i % 16));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev_q <= 1'b0;
                    cap_q  <= 1'b0;
                end else begin
                    prev_q <= src_in[i];
                    cap_q  <= hit | (cap_q & ~clr);
                end
            end
            assign pend[i] = en_ok && det_en && (cfg[i].sense[1] ? cap_q : active);
        end else begin : g_level
            assign pend[i] = en_ok && det_en && active;
        end
    end

endmodule

// File: rtl/ext_irq_arb.sv
module ext_irq_arb
    import ext_irq_pkg::*;
#(
    parameter int NSRC  = 64,
    parameter int SRC_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]     pend,
    input  src_cfg_t [NSRC-1:0] cfg,
    output logic [SRC_W-1:0]    win_code,
    output logic                win_vld
);

    localparam logic [SRC_W-1:0] NONE = SRC_W'(NSRC - 1);

    logic              found;
    logic [PRIO_W-1:0] best_p;

    always_comb begin
        found    = 1'b0;
        best_p   = '0;
        win_code = NONE;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i] && (!found || cfg[i].prio > best_p)) begin
                found    = 1'b1;
                best_p   = cfg[i].prio;
                win_code = SRC_W'(i);
            end
        end
        win_vld = found && (win_code != NONE);
    end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int NSRC    = 64,
    parameter int EDGE_LO = 47,
    parameter int N_EDGE  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [11:0]     addr,
    input  logic [31:0]     wdata,
    output logic [31:0]     rdata,
    input  logic [NSRC-1:0] src_in,
    output logic            irq_req
);

    localparam int SRC_W = $clog2(NSRC);
    localparam logic [SRC_W-1:0] NONE = SRC_W'(NSRC - 1);

    src_cfg_t [NSRC-1:0] cfg;
    logic                det_en, out_en, clr_vld, win_vld, fire;
    logic [3:0]          clr_idx;
    logic [NSRC-1:0]     pend;
    logic [SRC_W-1:0]    win_code, code_q;
    irq_state_e          state_q, state_d;

    ext_irq_regs #(.NSRC(NSRC), .SRC_W(SRC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .code(code_q), .cfg(cfg), .det_en(det_en), .out_en(out_en),
        .clr_vld(clr_vld), .clr_idx(clr_idx), .rdata(rdata)
    );

    ext_irq_detect #(.NSRC(NSRC), .EDGE_LO(EDGE_LO), .N_EDGE(N_EDGE)) u_detect (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .cfg(cfg), .det_en(det_en),
        .clr_vld(clr_vld), .clr_idx(clr_idx), .pend(pend)
    );

    ext_irq_arb #(.NSRC(NSRC), .SRC_W(SRC_W)) u_arb (
        .pend(pend), .cfg(cfg), .win_code(win_code), .win_vld(win_vld)
    );

    assign fire = win_vld && det_en && out_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
            code_q  <= NONE;
        end else begin
            state_q <= state_d;
            code_q  <= win_code;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (fire)  state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (!fire) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq_req = (state_q == IRQ_ACTIVE);
    end

endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk #(
    parameter int NSRC  = 64,
    parameter int SRC_W = $clog2(NSRC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_req,
    input logic [SRC_W-1:0] code,
    input logic             det_en,
    input logic             out_en,
    input logic [NSRC-1:0]  pend
);

    localparam logic [SRC_W-1:0] NONE = SRC_W'(NSRC - 1);

    logic [NSRC-1:0] pend_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend;
    end

    AST_REQ_GATED:    assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> $past(det_en && out_en)); // R9
    AST_REQ_VALID:    assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> code != NONE); // R10
    AST_DET_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !$past(det_en) |-> (code == NONE && !irq_req)); // R8
    AST_WIN_PENDING:  assert property (@(posedge clk) disable iff (!rst_n) (code != NONE) |-> pend_q[code]); // R7

endmodule

bind ext_irq_ctrl ext_irq_chk #(.NSRC(NSRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .code(code_q),
    .det_en(det_en), .out_en(out_en), .pend(pend)
);

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] src_in = '0;
    logic        irq_req;

    int checks = 0;
    int fails  = 0;

    bit       m_en  [64];
    bit [1:0] m_sn  [64];
    bit [7:0] m_pr  [64];
    bit       m_det, m_oe;

    always #5 clk = ~clk;

    ext_irq_ctrl i_ext_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .src_in(src_in), .irq_req(irq_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_src(input int s, input logic [1:0] en, input logic [1:0] sn, input logic [7:0] p);
        wr(12'(12'h200 + 8 * s), {2'b0, en, 2'b0, sn, 24'b0});
        wr(12'(12'h204 + 8 * s), {24'b0, p});
        m_en[s] = (en == 2'b11); m_sn[s] = sn; m_pr[s] = p;
    endtask

    task automatic mask_all();
        for (int s = 0; s < 64; s++) begin
            wr(12'(12'h200 + 8 * s), 32'h0);
            m_en[s] = 1'b0;
        end
    endtask

    function automatic int exp_code(input logic [63:0] v);
        int best = 63;
        int bp   = -1;
        for (int i = 0; i < 64; i++) begin
            if (m_en[i] && m_det && (m_sn[i][0] ? v[i] : !v[i]) && int'(m_pr[i]) > bp) begin
                best = i; bp = int'(m_pr[i]);
            end
        end
        return best;
    endfunction

    task automatic chk_out(input string req, input int exp);
        logic [31:0] d;
        rd(12'h144, d);
        chk(req, d, {8'(exp), 24'b0});
        chk(req, {31'b0, irq_req}, {31'b0, (exp != 63) && m_det && m_oe});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        m_det = 0; m_oe = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset values
        rd(12'h144, d); chk("R1 status", d, 32'h3F00_0000);
        chk("R1 irq", {31'b0, irq_req}, 32'h0);
        rd(12'h084, d); chk("R1 mask", d, 32'h0);
        rd(12'h004, d); chk("R1 det", d, 32'h0);
        rd(12'h444, d); chk("R1 oe", d, 32'h0);

        // R2 readback of stored fields only
        wr(12'h200 + 8 * 5, 32'hFFFF_FFFF);
        rd(12'h200 + 8 * 5, d); chk("R2 word0", d, 32'h3307_00F0);
        wr(12'h204 + 8 * 5, 32'hFFFF_FFA5);
        rd(12'h204 + 8 * 5, d); chk("R2 word1", d, 32'h0000_00A5);
        wr(12'h200 + 8 * 5, 32'h0);

        wr(12'h004, 32'h1); m_det = 1;
        wr(12'h444, 32'h1); m_oe = 1;

        // R3 partial enables never selected
        cfg_src(3, 2'b01, 2'b01, 8'd9);
        src_in[3] = 1'b1; settle();
        chk_out("R3 en01", 63);
        cfg_src(3, 2'b10, 2'b01, 8'd9); settle();
        chk_out("R3 en10", 63);
        cfg_src(3, 2'b11, 2'b01, 8'd9); settle();
        chk_out("R3 en11", 3);
        src_in[3] = 1'b0; settle();
        chk_out("R3 low", 63);

        // R4 polarity; non-edge source with sense 3 behaves as level high
        cfg_src(10, 2'b11, 2'b11, 8'd4);
        src_in[10] = 1'b1; settle(); chk_out("R4 s10 high", 10);
        src_in[10] = 1'b0; settle(); chk_out("R4 s10 low", 63);
        cfg_src(10, 2'b11, 2'b00, 8'd4); settle(); chk_out("R4 activelow", 10);
        src_in[10] = 1'b1; settle(); chk_out("R4 activelow idle", 63);
        mask_all(); src_in = '0;

        // R5 rising edge on 47 held after release
        cfg_src(47, 2'b11, 2'b11, 8'd5);
        src_in[47] = 1'b1; settle(); src_in[47] = 1'b0; settle();
        chk_out("R5 rise held", 47);
        // R6 clear with bit 8 = 0 ignored, with bit 8 clears nibble F
        wr(12'h0C0, 32'h0000_000F); settle(); chk_out("R6 no clear", 47);
        wr(12'h0C0, 32'h0000_0100); settle(); chk_out("R6 wrong nibble", 47);
        wr(12'h0C0, 32'h0000_010F); settle(); m_en[47] = 0;
        chk_out("R6 cleared", 63);
        // R5 falling edge on 48 (nibble 0)
        cfg_src(48, 2'b11, 2'b10, 8'd6);
        src_in[48] = 1'b1; settle(); chk_out("R5 fall none", 63);
        src_in[48] = 1'b0; settle(); src_in[48] = 1'b1; settle();
        chk_out("R5 fall held", 48);
        wr(12'h0C0, 32'h0000_0100); settle();
        chk_out("R6 clear 48", 63);
        mask_all(); src_in = '0;

        // R8 detection off: no pending, no latch
        wr(12'h004, 32'h0); m_det = 0;
        cfg_src(49, 2'b11, 2'b11, 8'd7);
        cfg_src(20, 2'b11, 2'b01, 8'd1);
        src_in[20] = 1'b1; src_in[49] = 1'b1; settle();
        chk_out("R8 det off", 63);
        src_in[49] = 1'b0;
        wr(12'h004, 32'h1); m_det = 1; settle();
        chk_out("R8 no latch", 20);

        // R9 output gate off: code valid, request low
        wr(12'h444, 32'h0); m_oe = 0; settle();
        chk_out("R9 oe off", 20);
        wr(12'h444, 32'h1); m_oe = 1; settle();
        chk_out("R9 oe on", 20);
        mask_all(); src_in = '0;

        // R10 source 63 alone
        cfg_src(63, 2'b11, 2'b01, 8'd200);
        src_in[63] = 1'b1; settle();
        chk_out("R10 src63", 63);
        mask_all(); src_in = '0;

        // R7 ties go to lowest number
        cfg_src(30, 2'b11, 2'b01, 8'd8);
        cfg_src(12, 2'b11, 2'b01, 8'd8);
        cfg_src(40, 2'b11, 2'b01, 8'd3);
        src_in[30] = 1; src_in[12] = 1; src_in[40] = 1; settle();
        chk_out("R7 tie", 12);

        // R7 random priorities and inputs
        for (int s = 0; s < 64; s++) begin
            logic [1:0] en = ($urandom % 4 != 0) ? 2'b11 : 2'(($urandom % 3));
            logic       hb = 1'($urandom);
            logic       eb = (s >= 47 && s <= 50) ? 1'b0 : 1'($urandom);
            cfg_src(s, en, {eb, hb}, 8'($urandom % 8));
        end
        for (int it = 0; it < 30; it++) begin
            src_in = {$urandom, $urandom};
            if (it % 5 == 4) begin
                int s = int'($urandom % 64);
                cfg_src(s, 2'b11, {1'b0, 1'($urandom)}, 8'($urandom % 8));
            end
            settle();
            chk_out("R7 random", exp_code(src_in));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule